// File: doc/BRIEF.md
# Matrix Keypad Scanning Encoder

This block is a synchronous controller for a 4x4 switch matrix. It enables one row line at a time and pulls that line low. The other row lines are released to high impedance. The four column lines carry external pull-ups, so a column reads 0 only when a closed switch joins it to the active row. After a short synchronizer the controller looks at the columns. When one or more of them is low, it turns the row number and the column number into a 4-bit hexadecimal key code. It stores that code and raises a one-cycle valid strobe. It then waits until the key is released before it scans again.

The state machine steps only on a slow scan tick from an external enable. The tick is typically a few hundred hertz and comes from a divider outside this block, while the block itself runs on the system clock. Each row pin is a tri-state pad: `row_o` carries the level to drive and `row_oe_o` turns that pad's driver on. Two keys pressed in one column therefore never connect two driven rows.

Top module: `keypad_scan_enc`

## Requirements
- R1: A synchronous active-high reset enables row 0 only and clears `key_code_o` and `key_valid_o` to 0. The next tick is then evaluated in the scanning state.
- R2: In every cycle exactly one bit of `row_oe_o` is 1, and `row_o` is 0 at that enabled position. Bit r of `row_oe_o` enables row r.
- R3: While scanning, a tick with all synchronized columns high moves the enable to the next row, and row 3 wraps to row 0. Without a tick, the enabled row never changes.
- R4: The key code equals row*4 + column. Column c is bit c of `col_n_i`, and a low bit means a closed switch.
- R5: When several columns are low in the scanned row, the lowest-numbered column sets the code.
- R6: A tick that finds a low column while scanning latches the code and raises `key_valid_o` for exactly the following cycle. `key_code_o` changes at no other time.
- R7: After a capture the enabled row stays put, and no further strobe occurs while any column is low at a tick. The first tick that finds all columns high resumes scanning at the next row.
- R8: The columns pass through two register stages before the state machine sees them. A tick that arrives in the first or second cycle after a column falls acts on the old column value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_tick | input | 1 | One-cycle scan step enable |
| col_n_i | input | 4 | Column lines, pulled up, low when a key is closed |
| row_o | output | 4 | Level driven on each row pad when enabled (always low) |
| row_oe_o | output | 4 | Per-row tri-state output enable, one-hot |
| key_code_o | output | 4 | Latched hexadecimal key code |
| key_valid_o | output | 1 | One-cycle strobe when a new code is latched |

## Verification
A scan tick can fall in the same cycle as a column edge that is still working its way through the two-stage synchronizer. That tick must then decide between capturing the key and stepping to the next row, using only the value the synchronizer has already delivered. The bench presses keys at every phase from zero to three cycles before a tick and holds ticks high across several cycles. A behavioural model with its own two-cycle column delay predicts the row enable, code and strobe, and the bench compares them on every clock.

// File: rtl/keypad_scan_pkg.sv
package keypad_scan_pkg;

  typedef enum logic [0:0] {
    ST_SCAN = 1'b0,
    ST_HOLD = 1'b1
  } scan_state_e;

  // Key code arithmetic: rows are numbered major, columns minor.
  function automatic int unsigned pack_code(input int unsigned row,
                                            input int unsigned col,
                                            input int unsigned ncols);
    return row * ncols + col;
  endfunction

  function automatic int unsigned next_row(input int unsigned row,
                                           input int unsigned nrows);
    return (row == nrows - 1) ? 0 : row + 1;
  endfunction

endpackage

// File: rtl/keypad_col_sync.sv
module keypad_col_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stage_q;

  // Idle (pulled-up) level is all ones, so reset loads ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '1;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/keypad_col_pick.sv
module keypad_col_pick #(
  parameter int COLS  = 4,
  parameter int COL_W = 2
) (
  input  logic [COLS-1:0]  col_s_i,
  output logic             any_low_o,
  output logic [COL_W-1:0] col_idx_o
);

  // Descending walk: the last hit written is the lowest-numbered column.
  always_comb begin
    any_low_o = 1'b0;
    col_idx_o = '0;
    for (int c = COLS - 1; c >= 0; c--) begin
      if (!col_s_i[c]) begin
        any_low_o = 1'b1;
        col_idx_o = COL_W'(c);
      end
    end
  end

endmodule

// File: rtl/keypad_scan_fsm.sv
module keypad_scan_fsm
  import keypad_scan_pkg::*;
#(
  parameter int ROWS   = 4,
  parameter int COLS   = 4,
  parameter int ROW_W  = 2,
  parameter int COL_W  = 2,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scan_tick,
  input  logic              any_low_i,
  input  logic [COL_W-1:0]  col_idx_i,
  output logic [ROW_W-1:0]  row_idx_o,
  output logic [CODE_W-1:0] key_code_o,
  output logic              key_valid_o,
  output logic              hit_evt_o,
  output logic              adv_evt_o
);

  scan_state_e state_q;
  logic        release_evt;

  assign hit_evt_o   = (state_q == ST_SCAN) && scan_tick && any_low_i;
  assign release_evt = (state_q == ST_HOLD) && scan_tick && !any_low_i;
  assign adv_evt_o   = ((state_q == ST_SCAN) && scan_tick && !any_low_i) || release_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_SCAN;
      row_idx_o   <= '0;
      key_code_o  <= '0;
      key_valid_o <= 1'b0;
    end else begin
      key_valid_o <= hit_evt_o;
      if (hit_evt_o) begin
        state_q    <= ST_HOLD;
        key_code_o <= CODE_W'(pack_code(int'(row_idx_o), int'(col_idx_i), COLS));
      end else if (release_evt) begin
        state_q <= ST_SCAN;
      end
      if (adv_evt_o) begin
        row_idx_o <= ROW_W'(next_row(int'(row_idx_o), ROWS));
      end
    end
  end

endmodule

// File: rtl/keypad_scan_enc.sv
module keypad_scan_enc #(
  parameter int ROWS        = 4,
  parameter int COLS        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scan_tick,
  input  logic [3:0] col_n_i,
  output logic [3:0] row_o,
  output logic [3:0] row_oe_o,
  output logic [3:0] key_code_o,
  output logic       key_valid_o
);

  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1;
  localparam int CODE_W = $clog2(ROWS * COLS);

  logic [COLS-1:0]  col_s;
  logic             any_low;
  logic [COL_W-1:0] col_idx;
  logic [ROW_W-1:0] row_idx;
  logic             hit_evt;
  logic             adv_evt;

  keypad_col_sync #(.W(COLS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (col_n_i),
    .q_o (col_s)
  );

  keypad_col_pick #(.COLS(COLS), .COL_W(COL_W)) u_pick (
    .col_s_i   (col_s),
    .any_low_o (any_low),
    .col_idx_o (col_idx)
  );

  keypad_scan_fsm #(
    .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W), .CODE_W(CODE_W)
  ) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .scan_tick   (scan_tick),
    .any_low_i   (any_low),
    .col_idx_i   (col_idx),
    .row_idx_o   (row_idx),
    .key_code_o  (key_code_o),
    .key_valid_o (key_valid_o),
    .hit_evt_o   (hit_evt),
    .adv_evt_o   (adv_evt)
  );

  // Row pads: active row pulled low, the rest released.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_oe_o[r] = (row_idx == ROW_W'(r));
    assign row_o[r]    = 1'b0;
  end

endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk (
  input logic       clk,
  input logic       rst,
  input logic       scan_tick,
  input logic [3:0] row_o,
  input logic [3:0] row_oe_o,
  input logic [3:0] key_code_o,
  input logic       key_valid_o,
  input logic       hit_evt,
  input logic       adv_evt
);

  AST_ONE_ROW_ENABLED: assert property (@(posedge clk) disable iff (rst) $countones(row_oe_o) == 1); // R2
  AST_ENABLED_ROW_LOW: assert property (@(posedge clk) disable iff (rst) (row_o & row_oe_o) == 4'b0); // R2
  AST_NO_TICK_NO_MOVE: assert property (@(posedge clk) disable iff (rst) !scan_tick |=> $stable(row_oe_o)); // R3
  AST_ADV_MOVES_ROW: assert property (@(posedge clk) disable iff (rst) adv_evt |=> !$stable(row_oe_o)); // R3
  AST_HIT_STROBES: assert property (@(posedge clk) disable iff (rst) hit_evt |=> key_valid_o); // R6
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) key_valid_o |=> !key_valid_o); // R6
  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (rst) !key_valid_o |-> $stable(key_code_o)); // R6
  AST_CAPTURE_HOLDS_ROW: assert property (@(posedge clk) disable iff (rst) key_valid_o |-> $stable(row_oe_o)); // R7
  AST_NO_DOUBLE_HIT: assert property (@(posedge clk) disable iff (rst) hit_evt |=> !hit_evt); // R7

endmodule

bind keypad_scan_enc keypad_scan_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .scan_tick   (scan_tick),
  .row_o       (row_o),
  .row_oe_o    (row_oe_o),
  .key_code_o  (key_code_o),
  .key_valid_o (key_valid_o),
  .hit_evt     (hit_evt),
  .adv_evt     (adv_evt)
);

// File: tb/keypad_scan_enc_tb.sv
module keypad_scan_enc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scan_tick = 1'b0;
  logic [3:0]  col_n;
  logic [3:0]  row_o;
  logic [3:0]  row_oe;
  logic [3:0]  key_code;
  logic        key_valid;
  logic [15:0] pressed = '0;   // bit r*4+c = switch at row r, column c closed

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int vcount = 0;
  bit done   = 0;

  // reference model state
  int m_row = 0, m_code = 0, m_s1 = 15, m_s2 = 15;
  bit m_hold = 0, m_valid = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keypad_scan_enc dut_i (
    .clk (clk), .rst (rst), .scan_tick (scan_tick), .col_n_i (col_n),
    .row_o (row_o), .row_oe_o (row_oe), .key_code_o (key_code), .key_valid_o (key_valid)
  );

  // Switch matrix with pulled-up columns; only enabled rows can pull low.
  always_comb begin
    for (int c = 0; c < 4; c++) begin
      col_n[c] = 1'b1;
      for (int r = 0; r < 4; r++)
        if (pressed[r*4+c] && row_oe[r] && !row_o[r]) col_n[c] = 1'b0;
    end
  end

  function automatic int raw_cols(input logic [15:0] p, input int row);
    int v = 15;
    for (int c = 0; c < 4; c++) if (p[row*4+c]) v = v & ~(1 << c);
    return v;
  endfunction

  always @(posedge clk) begin
    int raw, low, lc;
    raw = raw_cols(pressed, m_row);
    if (rst) begin
      m_row = 0; m_hold = 0; m_code = 0; m_valid = 0; m_s1 = 15; m_s2 = 15;
    end else begin
      low = ~m_s2 & 15;
      m_valid = 0;
      if (scan_tick) begin
        if (!m_hold) begin
          if (low != 0) begin
            lc = 3;
            while (lc > 0 && ((low >> (lc - 1)) & 1) == 1) lc--;
            for (int c = 3; c >= 0; c--) if ((low >> c) & 1) lc = c;
            m_code = m_row * 4 + lc; m_valid = 1; m_hold = 1;
          end else m_row = (m_row + 1) % 4;
        end else if (low == 0) begin
          m_hold = 0; m_row = (m_row + 1) % 4;
        end
      end
      m_s2 = m_s1; m_s1 = raw;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Per-clock comparison against the model, away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (key_valid) vcount++;
    if (!rst && !done) begin
      check(row_oe == 4'(1 << m_row), "R2 R3 row enable", int'(row_oe), 1 << m_row);
      check((row_o & row_oe) == 4'b0, "R2 active row level", int'(row_o & row_oe), 0);
      check(int'(key_code) == m_code, "R4 R5 key code", int'(key_code), m_code);
      check(key_valid == m_valid, "R6 strobe", int'(key_valid), int'(m_valid));
    end
    if (cyc > WATCHDOG && !done) begin
      fails++;
      $display("FAIL watchdog R1 actual=%0d cycles expected<%0d", cyc, WATCHDOG);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick(input int len);
    @(negedge clk); scan_tick = 1'b1;
    repeat (len) @(negedge clk);
    scan_tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin tick(1); idle(3); end
  endtask

  initial begin
    int v0;
    idle(4);
    check(row_oe == 4'b0001 && key_code == 4'h0 && key_valid == 1'b0, "R1 reset state",
          {row_oe, key_code}, 8'h10);
    @(negedge clk); rst = 1'b0;
    idle(3);

    // R3: idle ticks walk rows and wrap
    ticks(5);
    check(row_oe == 4'b0010, "R3 wrap after five ticks", int'(row_oe), 2);

    // R4: key at row 2, column 1 -> code 9
    v0 = vcount;
    @(negedge clk); pressed = 16'(1 << 9);
    ticks(6);
    check(key_code == 4'h9, "R4 code row2 col1", int'(key_code), 9);
    check(vcount - v0 == 1, "R6 single strobe", vcount - v0, 1);
    // R7: holding produces no more strobes, row stays
    ticks(4);
    check(row_oe == 4'b0100, "R7 row held while pressed", int'(row_oe), 4);
    check(vcount - v0 == 1, "R7 no repeat strobe", vcount - v0, 1);
    @(negedge clk); pressed = '0;
    idle(3); ticks(1);
    check(row_oe == 4'b1000, "R7 resume at next row", int'(row_oe), 8);

    // R5: row 1, columns 3 and 0 -> code 4
    @(negedge clk); pressed = 16'((1 << 7) | (1 << 4));
    ticks(6);
    check(key_code == 4'h4, "R5 lowest column wins", int'(key_code), 4);
    @(negedge clk); pressed = '0; idle(3); ticks(1);

    // R2: two keys in one column, rows 0 and 3
    @(negedge clk); pressed = 16'((1 << 2) | (1 << 14));
    ticks(6);
    check(key_code == 4'h2 || key_code == 4'he, "R2 same-column pair", int'(key_code), 2);
    @(negedge clk); pressed = '0; idle(3); ticks(1);

    // R8: press on current row then tick right away: old value used
    idle(3);
    v0 = vcount;
    @(negedge clk); pressed = 16'(1 << (m_row * 4 + 3));
    scan_tick = 1'b1; @(negedge clk); scan_tick = 1'b0;
    idle(3);
    check(vcount == v0, "R8 tick inside sync delay ignored", vcount - v0, 0);
    @(negedge clk); pressed = '0; idle(3); ticks(2);

    // R8 phases and long ticks against the model
    for (int ph = 0; ph < 4; ph++) begin
      @(negedge clk); pressed = 16'(1 << (m_row * 4 + ph));
      idle(ph);
      tick(1 + ph); idle(2); ticks(3);
      @(negedge clk); pressed = '0;
      idle(ph); tick(2); idle(3); ticks(2);
    end

    // random presses
    for (int i = 0; i < 60; i++) begin
      @(negedge clk); pressed = 16'($urandom_range(0, 65535) & $urandom_range(0, 65535));
      idle($urandom_range(0, 3));
      ticks($urandom_range(1, 6));
      tick($urandom_range(1, 3));
      @(negedge clk); pressed = '0;
      idle($urandom_range(0, 3));
      ticks($urandom_range(1, 3));
    end

    // R1: reset in the middle of a hold
    @(negedge clk); pressed = 16'(1 << (m_row * 4 + 1));
    ticks(5);
    @(negedge clk); rst = 1'b1;
    idle(3);
    check(row_oe == 4'b0001 && key_code == 4'h0 && key_valid == 1'b0, "R1 reset clears",
          {row_oe, key_code}, 8'h10);
    @(negedge clk); rst = 1'b0; pressed = '0;
    idle(3); ticks(3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule